// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the instruction stream of a five-stage integer pipeline (fetch, decode, execute, memory, writeback) and decides, cycle by cycle, whether a read-after-write dependency must be resolved. The decode stage presents its source and destination register fields to the block each cycle. The block keeps a small record of the destinations held by the execute, memory and writeback stages. From this it drives the select lines of the two ALU operand multiplexers and a stall that freezes the program counter and the fetch/decode register while a bubble enters execute.

A two-bit run-time mode selects full forwarding, stall-only resolution, or no resolution at all. With no resolution, a dependent instruction reads whatever the register file holds, which may be stale. The register file is assumed to write in the first half of the cycle, so a producer three slots ahead never needs help. A per-cycle status code exposes each decision.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset no stall is requested, both operand selects are 00 and the status is 00, until a writing instruction has been issued.
- R2: The mode encoding is 00 = no resolution, 01 = stall-only, 10 = forwarding; 11 behaves as 00. In no-resolution mode the block never stalls and never forwards, even on a back-to-back dependency.
- R3: In stall-only mode, an instruction that reads the destination of the instruction issued just before it is held in decode for exactly two cycles.
- R4: In stall-only mode, an instruction that reads the destination of the instruction issued two slots earlier is held for exactly one cycle.
- R5: A producer issued three or more slots before its consumer causes no stall and no forwarding in any mode.
- R6: In forwarding mode each operand select is chosen on its own: 01 takes the memory-stage result, 10 takes the writeback-stage result, 00 takes the register file. Operand A follows the first source and operand B the second.
- R7: When both the memory and the writeback stage hold the register an operand needs, the select is 01.
- R8: Register 0 as a destination never causes a stall or a forward.
- R9: In forwarding mode, an instruction that reads the destination of a load issued just before it is held for one cycle and then gets select 10 on that operand.
- R10: A stall raises the program counter hold, the fetch/decode hold and the execute bubble together; the bubble writes no register and so never itself causes a stall or a forward.
- R11: The status output is 10 when stalling, otherwise 01 when either operand select is non-zero, otherwise 00.
- R12: A source whose use flag is low is ignored for both stalling and forwarding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Resolution mode (00 none, 01 stall-only, 10 forwarding, 11 none) |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| id_rs1 | input | RW | First source register |
| id_rs2 | input | RW | Second source register |
| id_rd | input | RW | Destination register |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| fwd_a | output | 2 | Operand A select for the execute instruction |
| fwd_b | output | 2 | Operand B select for the execute instruction |
| stall_pc | output | 1 | Hold the program counter |
| stall_fd | output | 1 | Hold the fetch/decode register |
| flush_ex | output | 1 | Insert a bubble into execute |
| status | output | 2 | Decision code (00 none, 01 forward, 10 stall) |

## Verification
A corrupted stage record shows up one or two cycles later, when the consumer reaches decode or execute: a missing destination drops a stall or a select, while a stale one raises a stall or a select where the stream has none. A wrong stall length is visible as the number of cycles one decode instruction is held, so stall counts of two, one and zero are measured for each distance. Random streams over a few registers, with the mode changed mid-stream, are compared every cycle against a slot-by-slot model built from the requirements.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          id_valid,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] id_rd,
  input  logic          id_wen,
  input  logic          id_load,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall_pc,
  output logic          stall_fd,
  output logic          flush_ex,
  output logic [1:0]    status
);
  localparam logic [1:0] M_STALL = 2'b01;
  localparam logic [1:0] M_FWD   = 2'b10;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_WB  = 2'b10;

  logic          ex_wen, ex_load, ex_use1, ex_use2;
  logic [RW-1:0] ex_rd, ex_rs1, ex_rs2;
  logic          mem_wen;
  logic [RW-1:0] mem_rd;
  logic          wb_wen;
  logic [RW-1:0] wb_rd;

  function automatic logic reads(input logic w, input logic [RW-1:0] rd,
                                 input logic u1, input logic [RW-1:0] s1,
                                 input logic u2, input logic [RW-1:0] s2);
    return w && (rd != '0) && ((u1 && s1 == rd) || (u2 && s2 == rd));
  endfunction

  function automatic logic [1:0] pick(input logic u, input logic [RW-1:0] s);
    if (mode != M_FWD || !u || s == '0) return SEL_RF;
    if (mem_wen && mem_rd == s)          return SEL_MEM;
    if (wb_wen && wb_rd == s)            return SEL_WB;
    return SEL_RF;
  endfunction

  logic u1, u2, hit_ex, hit_mem, stall;

  assign u1      = id_valid && id_use1;
  assign u2      = id_valid && id_use2;
  assign hit_ex  = reads(ex_wen, ex_rd, u1, id_rs1, u2, id_rs2);
  assign hit_mem = reads(mem_wen, mem_rd, u1, id_rs1, u2, id_rs2);

  always_comb begin
    case (mode)
      M_STALL: stall = hit_ex || hit_mem;
      M_FWD:   stall = hit_ex && ex_load;
      default: stall = 1'b0;
    endcase
  end

  assign fwd_a    = pick(ex_use1, ex_rs1);
  assign fwd_b    = pick(ex_use2, ex_rs2);
  assign stall_pc = stall;
  assign stall_fd = stall;
  assign flush_ex = stall;
  assign status   = stall ? 2'b10 : ((fwd_a != SEL_RF || fwd_b != SEL_RF) ? 2'b01 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_wen  <= 1'b0;
      ex_load <= 1'b0;
      ex_use1 <= 1'b0;
      ex_use2 <= 1'b0;
      ex_rd   <= '0;
      ex_rs1  <= '0;
      ex_rs2  <= '0;
      mem_wen <= 1'b0;
      mem_rd  <= '0;
      wb_wen  <= 1'b0;
      wb_rd   <= '0;
    end else begin
      wb_wen  <= mem_wen;
      wb_rd   <= mem_rd;
      mem_wen <= ex_wen;
      mem_rd  <= ex_rd;
      if (stall || !id_valid) begin
        ex_wen  <= 1'b0;
        ex_load <= 1'b0;
        ex_use1 <= 1'b0;
        ex_use2 <= 1'b0;
        ex_rd   <= '0;
        ex_rs1  <= '0;
        ex_rs2  <= '0;
      end else begin
        ex_wen  <= id_wen;
        ex_load <= id_load;
        ex_use1 <= id_use1;
        ex_use2 <= id_use2;
        ex_rd   <= id_rd;
        ex_rs1  <= id_rs1;
        ex_rs2  <= id_rs2;
      end
    end
  end
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall_pc,
  input logic [RW-1:0] ex_rs1,
  input logic [RW-1:0] ex_rs2
);
  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> (!stall_pc && fwd_a == 2'b00 && fwd_b == 2'b00));

  // R3
  stall_mode_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));

  // R6
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11 && fwd_b != 2'b11));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_rs1 == '0) |-> fwd_a == 2'b00) and ((ex_rs2 == '0) |-> fwd_b == 2'b00));

  // R9
  load_stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && stall_pc) |=> (mode != 2'b10 || !stall_pc));

  // R10
  bubble_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pc |=> (fwd_a == 2'b00 && fwd_b == 2'b00));
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .stall_pc(stall_pc), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2)
);

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
  localparam int RW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic id_valid = 1'b0, id_use1 = 1'b0, id_use2 = 1'b0, id_wen = 1'b0, id_load = 1'b0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic [1:0] fwd_a, fwd_b, status;
  logic stall_pc, stall_fd, flush_ex;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_ctrl #(.RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .id_valid(id_valid),
    .id_use1(id_use1), .id_use2(id_use2), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rd(id_rd), .id_wen(id_wen), .id_load(id_load),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_pc(stall_pc), .stall_fd(stall_fd),
    .flush_ex(flush_ex), .status(status)
  );

  // Reference slots: issued instructions at distance 1 (execute), 2 (memory), 3 (writeback)
  logic          s_wen [1:3];
  logic          s_ld  [1:3];
  logic [RW-1:0] s_rd  [1:3];
  logic          e_u1, e_u2;
  logic [RW-1:0] e_s1, e_s2;
  logic [1:0]    o_fa, o_fb;
  logic          o_st;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit needs(input int d);
    return s_wen[d] && s_rd[d] != 0 &&
           ((id_valid && id_use1 && id_rs1 == s_rd[d]) || (id_valid && id_use2 && id_rs2 == s_rd[d]));
  endfunction

  function automatic bit exp_stall();
    if (mode == 2'b01) return needs(1) || needs(2);
    if (mode == 2'b10) return needs(1) && s_ld[1];
    return 1'b0;
  endfunction

  function automatic logic [1:0] exp_sel(input logic u, input logic [RW-1:0] r);
    if (mode != 2'b10 || !u || r == 0) return 2'b00;
    if (s_wen[2] && s_rd[2] == r) return 2'b01;
    if (s_wen[3] && s_rd[3] == r) return 2'b10;
    return 2'b00;
  endfunction

  task automatic model_reset();
    for (int i = 1; i <= 3; i++) begin s_wen[i] = 0; s_ld[i] = 0; s_rd[i] = '0; end
    e_u1 = 0; e_u2 = 0; e_s1 = '0; e_s2 = '0;
  endtask

  task automatic cycle();
    logic st; logic [1:0] ea, eb, es;
    #1;
    st = exp_stall();
    ea = exp_sel(e_u1, e_s1);
    eb = exp_sel(e_u2, e_s2);
    es = st ? 2'b10 : ((ea != 0 || eb != 0) ? 2'b01 : 2'b00);
    chk(stall_pc == st, "R3/R4/R9 stall_pc", stall_pc, st);
    chk(stall_fd == st && flush_ex == st, "R10 stall group", {stall_fd, flush_ex}, {st, st});
    chk(fwd_a == ea, "R6/R7 fwd_a", fwd_a, ea);
    chk(fwd_b == eb, "R6/R7 fwd_b", fwd_b, eb);
    chk(status == es, "R11 status", status, es);
    o_st = stall_pc; o_fa = fwd_a; o_fb = fwd_b;
    @(posedge clk);
    for (int i = 3; i >= 2; i--) begin s_wen[i] = s_wen[i-1]; s_ld[i] = s_ld[i-1]; s_rd[i] = s_rd[i-1]; end
    if (st || !id_valid) begin
      s_wen[1] = 0; s_ld[1] = 0; s_rd[1] = '0; e_u1 = 0; e_u2 = 0; e_s1 = '0; e_s2 = '0;
    end else begin
      s_wen[1] = id_wen; s_ld[1] = id_load; s_rd[1] = id_rd;
      e_u1 = id_use1; e_u2 = id_use2; e_s1 = id_rs1; e_s2 = id_rs2;
    end
    @(negedge clk);
  endtask

  task automatic issue(input bit v, input bit u1, input int r1, input bit u2, input int r2,
                       input int rd, input bit w, input bit ld, output int stalls);
    id_valid = v; id_use1 = u1; id_rs1 = RW'(r1); id_use2 = u2; id_rs2 = RW'(r2);
    id_rd = RW'(rd); id_wen = w; id_load = ld;
    stalls = 0;
    for (int k = 0; k < 8; k++) begin
      cycle();
      if (!o_st) break;
      stalls++;
    end
  endtask

  task automatic nop(); int s; issue(0, 0, 0, 0, 0, 0, 0, 0, s); endtask

  task automatic flush_all(); repeat (4) nop(); endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    void'($urandom(32'h5eed_1a2b));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!stall_pc && fwd_a == 0 && fwd_b == 0 && status == 0, "R1 reset state", status, 0);
    @(negedge clk);

    // R3: stall-only, adjacent
    mode = 2'b01;
    issue(1, 0, 0, 0, 0, 5, 1, 0, s);
    issue(1, 1, 5, 0, 0, 6, 1, 0, s);
    chk(s == 2, "R3 adjacent stall count", s, 2);
    flush_all();
    // R4: stall-only, distance two
    issue(1, 0, 0, 0, 0, 6, 1, 0, s);
    issue(1, 0, 0, 0, 0, 1, 1, 0, s);
    issue(1, 0, 0, 1, 6, 2, 1, 0, s);
    chk(s == 1, "R4 distance-two stall count", s, 1);
    flush_all();
    // R5: distance three in stall-only and forwarding
    for (int m = 1; m <= 2; m++) begin
      mode = 2'(m);
      issue(1, 0, 0, 0, 0, 7, 1, 0, s);
      issue(1, 0, 0, 0, 0, 1, 1, 0, s);
      issue(1, 0, 0, 0, 0, 2, 1, 0, s);
      issue(1, 1, 7, 1, 7, 3, 1, 0, s);
      chk(s == 0, "R5 distance-three stall", s, 0);
      nop();
      chk(o_fa == 0 && o_fb == 0, "R5 distance-three no forward", o_fa, 0);
      flush_all();
    end
    // R6: forwarding from memory on both operands
    mode = 2'b10;
    issue(1, 0, 0, 0, 0, 5, 1, 0, s);
    issue(1, 1, 5, 1, 5, 9, 1, 0, s);
    chk(s == 0, "R6 no stall with forwarding", s, 0);
    nop();
    chk(o_fa == 2'b01 && o_fb == 2'b01, "R6 memory select", {o_fa, o_fb}, 4'b0101);
    flush_all();
    // R6: forwarding from writeback on operand B only
    issue(1, 0, 0, 0, 0, 8, 1, 0, s);
    issue(1, 0, 0, 0, 0, 1, 1, 0, s);
    issue(1, 1, 3, 1, 8, 2, 1, 0, s);
    nop();
    chk(o_fa == 2'b00 && o_fb == 2'b10, "R6 writeback select", {o_fa, o_fb}, 4'b0010);
    flush_all();
    // R7: memory stage wins over writeback
    issue(1, 0, 0, 0, 0, 9, 1, 0, s);
    issue(1, 0, 0, 0, 0, 9, 1, 0, s);
    issue(1, 1, 9, 0, 0, 1, 1, 0, s);
    nop();
    chk(o_fa == 2'b01, "R7 memory priority", o_fa, 1);
    flush_all();
    // R8: register 0
    for (int m = 1; m <= 2; m++) begin
      mode = 2'(m);
      issue(1, 0, 0, 0, 0, 0, 1, 1, s);
      issue(1, 1, 0, 1, 0, 4, 1, 0, s);
      chk(s == 0, "R8 x0 no stall", s, 0);
      nop();
      chk(o_fa == 0 && o_fb == 0, "R8 x0 no forward", o_fa, 0);
      flush_all();
    end
    // R9: load-use in forwarding mode
    mode = 2'b10;
    issue(1, 0, 0, 0, 0, 4, 1, 1, s);
    issue(1, 1, 4, 0, 0, 5, 1, 0, s);
    chk(s == 1, "R9 load-use stall count", s, 1);
    nop();
    chk(o_fa == 2'b10, "R9 load data from writeback", o_fa, 2);
    flush_all();
    // R12: unused source ignored
    mode = 2'b01;
    issue(1, 0, 0, 0, 0, 5, 1, 0, s);
    issue(1, 0, 5, 0, 5, 6, 1, 0, s);
    chk(s == 0, "R12 unused source no stall", s, 0);
    flush_all();
    mode = 2'b10;
    issue(1, 0, 0, 0, 0, 5, 1, 0, s);
    issue(1, 0, 5, 1, 5, 6, 1, 0, s);
    nop();
    chk(o_fa == 2'b00 && o_fb == 2'b01, "R12 unused source no forward", {o_fa, o_fb}, 4'b0001);
    flush_all();
    // R2: no resolution, both encodings
    for (int m = 0; m <= 3; m += 3) begin
      mode = 2'(m);
      issue(1, 0, 0, 0, 0, 5, 1, 1, s);
      issue(1, 1, 5, 1, 5, 6, 1, 0, s);
      chk(s == 0, "R2 none mode no stall", s, 0);
      nop();
      chk(o_fa == 0 && o_fb == 0, "R2 none mode no forward", {o_fa, o_fb}, 0);
      flush_all();
    end
    // R10: bubble after a stall causes nothing
    mode = 2'b01;
    issue(1, 0, 0, 0, 0, 3, 1, 0, s);
    issue(1, 1, 3, 0, 0, 4, 1, 0, s);
    chk(s == 2, "R10 stall with bubbles", s, 2);

    // Random streams with mid-stream mode changes
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) mode = 2'($urandom_range(0, 3));
      issue($urandom_range(0, 5) != 0, 1'($urandom), $urandom_range(0, 3),
            1'($urandom), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom), $urandom_range(0, 3) == 0, s);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule